// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a page table tree that has two levels and maps 4 KB pages. A walk starts with a one-cycle request. The block captures the logical address and the base address of the top-level table at that moment. It then fetches the top-level entry, which points at a second-level table. From that table it fetches the entry that names the final page frame. The physical address is that frame joined with the page offset.

Both fetches go through one memory read port. That port keeps a request asserted until the memory answers, however many cycles the answer takes. When a walk ends, the block raises a one-cycle completion pulse. It reports either the translated address or a fault code, and the code says which level held an entry marked not present. When the top-level entry is not present, the second fetch never happens.

Top module: `pt_walker`

## Requirements
- R1: During reset, `busy`, `mem_req` and `done` are 0, and `phys_addr` and `fault_code` read 0.
- R2: The first read goes to `table_base + 4 * laddr[31:22]`, using the values captured in the cycle that `start` was accepted while idle.
- R3: The second read goes to `{E1[31:12], 12'h000} + 4 * laddr[21:12]`, where E1 is the first-level entry. An entry is present when bit 0 is 1. Bits 11:1 carry no meaning and are ignored.
- R4: When both entries are present, `fault_code` is 0 and `phys_addr` is `{E2[31:12], laddr[11:0]}`, where E2 is the second-level entry.
- R5: When E1 is not present, the walk ends after exactly one read, with `fault_code` = 1 and `phys_addr` = 0.
- R6: When E2 is not present, the walk ends after two reads, with `fault_code` = 2 and `phys_addr` = 0.
- R7: `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_rvalid` is high. Any response delay is accepted, including a delay of zero cycles.
- R8: `busy` is high from the cycle after `start` is accepted through the `done` cycle. `done` is high for exactly one cycle, in the cycle after the final response, and `busy` is low in the cycle after it.
- R9: During a walk, `start` is ignored and changes on `laddr` or `table_base` are ignored. The walk in progress uses only its captured values.
- R10: `mem_rvalid` is ignored while no read is pending. While idle it starts nothing and changes no result.
- R11: `phys_addr` and `fault_code` hold their values from the most recent walk until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk; accepted only while idle |
| laddr | input | 32 | Logical address to translate |
| table_base | input | 32 | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Table read request, held until answered |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Table entry returned by memory |
| done | output | 1 | One-cycle pulse when a walk ends |
| phys_addr | output | 32 | Translated physical address, or 0 on a fault |
| fault_code | output | 2 | 0 = success, 1 = first-level fault, 2 = second-level fault |

## Verification
The hardest case to reach from the ports is a walk whose captured inputs are disturbed while a read is still outstanding. To reach it, the bench stretches the first read's response delay. During those wait cycles it raises `start` again and changes `laddr` and `table_base`. It then confirms that the held request address and the final result follow only the captured values. A table of vectors steers walks into each ending: success, a first-level fault with no second read, and a second-level fault. The vectors use zero, short and long response delays, extreme index values, and entries whose ignored low bits are set.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_OUTER = 2'd1;
  localparam logic [1:0] FLT_INNER = 2'd2;

endpackage

// File: rtl/pgw_entry_dec.sv
module pgw_entry_dec #(
  parameter int AW        = 32,
  parameter int OFF_W     = 12,
  parameter int VALID_BIT = 0
) (
  input  logic [AW-1:0]       entry,
  output logic                present,
  output logic [AW-OFF_W-1:0] frame
);

  assign present = entry[VALID_BIT];
  assign frame   = entry[AW-1:OFF_W];

endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int AW        = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic [AW-1:0]       va,
  input  logic [AW-1:0]       base,
  input  logic [AW-OFF_W-1:0] tbl_frame,
  input  logic [AW-OFF_W-1:0] leaf_frame,
  output logic [AW-1:0]       outer_addr,
  output logic [AW-1:0]       inner_addr,
  output logic [AW-1:0]       phys
);

  localparam int ENT_SH = $clog2(ENT_BYTES);

  // Byte address of entry idx inside a table starting at tbl.
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] tbl,
                                              input logic [IDX_W-1:0] idx);
    return tbl + (AW'(idx) << ENT_SH);
  endfunction

  // Byte address of the first byte of a frame.
  function automatic logic [AW-1:0] frame_base(input logic [AW-OFF_W-1:0] f);
    return {f, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] join_pa(input logic [AW-OFF_W-1:0] f,
                                            input logic [OFF_W-1:0] off);
    return {f, off};
  endfunction

  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] mid_idx;

  assign top_idx    = va[AW-1 -: IDX_W];
  assign mid_idx    = va[OFF_W +: IDX_W];
  assign outer_addr = slot_addr(base, top_idx);
  assign inner_addr = slot_addr(frame_base(tbl_frame), mid_idx);
  assign phys       = join_pa(leaf_frame, va[OFF_W-1:0]);

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       va_in,
  input  logic [AW-1:0]       base_in,
  input  logic                mem_rvalid,
  input  logic                ent_present,
  input  logic [AW-OFF_W-1:0] ent_frame,
  input  logic [AW-1:0]       outer_addr,
  input  logic [AW-1:0]       inner_addr,
  input  logic [AW-1:0]       phys,
  output logic                busy,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  output logic                done,
  output logic [AW-1:0]       va_q,
  output logic [AW-1:0]       base_q,
  output logic [AW-OFF_W-1:0] tbl_frame_q,
  output logic [AW-1:0]       pa_q,
  output logic [1:0]          fault_q
);

  walk_st_e state, state_nx;

  // Named internal events, used by the sequencing logic and the assertions.
  logic ev_accept, ev_outer_ok, ev_outer_bad, ev_inner_ok, ev_inner_bad, ev_finish;

  assign ev_accept    = (state == ST_IDLE) && start;
  assign ev_outer_ok  = (state == ST_OUTER) && mem_rvalid && ent_present;
  assign ev_outer_bad = (state == ST_OUTER) && mem_rvalid && !ent_present;
  assign ev_inner_ok  = (state == ST_INNER) && mem_rvalid && ent_present;
  assign ev_inner_bad = (state == ST_INNER) && mem_rvalid && !ent_present;
  assign ev_finish    = ev_outer_bad || ev_inner_ok || ev_inner_bad;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (ev_accept) state_nx = ST_OUTER;
      ST_OUTER: if (ev_outer_ok) state_nx = ST_INNER;
                else if (ev_outer_bad) state_nx = ST_DONE;
      ST_INNER: if (mem_rvalid) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      tbl_frame_q <= '0;
      pa_q        <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        va_q   <= va_in;
        base_q <= base_in;
      end
      if (ev_outer_ok) tbl_frame_q <= ent_frame;
      if (ev_outer_bad) begin
        pa_q    <= '0;
        fault_q <= FLT_OUTER;
      end
      if (ev_inner_bad) begin
        pa_q    <= '0;
        fault_q <= FLT_INNER;
      end
      if (ev_inner_ok) begin
        pa_q    <= phys;
        fault_q <= FLT_NONE;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign mem_req  = (state == ST_OUTER) || (state == ST_INNER);
  assign mem_addr = (state == ST_INNER) ? inner_addr : outer_addr;

  // R7: an unanswered request holds with a steady address
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R5: a missing first-level entry ends the walk with no second read
  a_r5_skip_inner: assert property (@(posedge clk) disable iff (!rst_n)
    ev_outer_bad |=> (done && !mem_req && fault_q == FLT_OUTER && pa_q == '0));

  // R6: a missing second-level entry yields code 2 and a zero address
  a_r6_inner_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inner_bad |=> (done && fault_q == FLT_INNER && pa_q == '0));

  // R4: on success the low address bits equal the captured offset
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_q == FLT_NONE) |-> (pa_q[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R8: completion is a single-cycle pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9: captured inputs stay put while a walk runs
  a_r9_captured: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(va_q) && $stable(base_q)));

  // R10: idle without start stays idle, whatever mem_rvalid does
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  // R11: results change only when a walk finishes
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_finish |=> ($stable(pa_q) && $stable(fault_q)));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW        = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] table_base,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] phys_addr,
  output logic [1:0]    fault_code
);

  localparam int FRAME_W = AW - OFF_W;

  logic               ent_present;
  logic [FRAME_W-1:0] ent_frame;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [AW-1:0]      va_q, base_q;
  logic [AW-1:0]      outer_addr, inner_addr, phys;

  pgw_entry_dec #(.AW(AW), .OFF_W(OFF_W), .VALID_BIT(0)) u_dec (
    .entry   (mem_rdata),
    .present (ent_present),
    .frame   (ent_frame)
  );

  pgw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_BYTES(ENT_BYTES)) u_addr (
    .va         (va_q),
    .base       (base_q),
    .tbl_frame  (tbl_frame_q),
    .leaf_frame (ent_frame),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr),
    .phys       (phys)
  );

  pgw_seq #(.AW(AW), .OFF_W(OFF_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .va_in       (laddr),
    .base_in     (table_base),
    .mem_rvalid  (mem_rvalid),
    .ent_present (ent_present),
    .ent_frame   (ent_frame),
    .outer_addr  (outer_addr),
    .inner_addr  (inner_addr),
    .phys        (phys),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .done        (done),
    .va_q        (va_q),
    .base_q      (base_q),
    .tbl_frame_q (tbl_frame_q),
    .pa_q        (phys_addr),
    .fault_q     (fault_code)
  );

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_3ABC, 32'h0001_0000, 32'h0002_0001, 32'h0ABC_D001, 8'd0},
    '{32'hFFFF_FFFF, 32'h0008_0000, 32'h0003_3001, 32'hFFFF_F001, 8'd3},
    '{32'h0000_0000, 32'h0000_0000, 32'h1234_5001, 32'h0000_1001, 8'd1},
    '{32'h1234_5678, 32'h0010_0000, 32'hABCD_EFFE, 32'h5555_5001, 8'd2},
    '{32'h8020_1FFF, 32'h0000_4000, 32'h0004_4FFF, 32'h7777_7FFE, 8'd5},
    '{32'h7FC0_0123, 32'h00FF_F000, 32'h000A_B00F, 32'hCAFE_B0E1, 8'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] laddr = '0;
  logic [31:0] table_base = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, mem_req, done;
  logic [31:0] mem_addr, phys_addr;
  logic [1:0]  fault_code;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .laddr      (laddr),
    .table_base (table_base),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .phys_addr  (phys_addr),
    .fault_code (fault_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of the translation, written from the requirements.
  function automatic logic [31:0] m_first(input vec_t v);
    return v.base + {20'd0, v.va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] m_second(input vec_t v);
    return (v.e1 & 32'hFFFF_F000) + {20'd0, v.va[21:12], 2'b00};
  endfunction
  function automatic logic [1:0] m_code(input vec_t v);
    if (!v.e1[0]) return 2'd1;
    if (!v.e2[0]) return 2'd2;
    return 2'd0;
  endfunction
  function automatic logic [31:0] m_pa(input vec_t v);
    return (m_code(v) != 2'd0) ? 32'h0 : ((v.e2 & 32'hFFFF_F000) | (v.va & 32'h0000_0FFF));
  endfunction

  task automatic run_walk(input vec_t v, input bit disturb);
    int reads = 0;
    int cyc = 0;
    logic [31:0] exp_a;
    @(negedge clk);
    laddr = v.va; table_base = v.base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after accept", 32'(busy), 32'd1);
    while (!done && cyc < 500) begin
      if (mem_req) begin
        exp_a = (reads == 0) ? m_first(v) : m_second(v);
        chk((reads == 0) ? "R2 first read address" : "R3 second read address", mem_addr, exp_a);
        for (int k = 0; k < int'(v.lat); k++) begin
          if (disturb && reads == 0) begin
            start = 1'b1; laddr = ~v.va; table_base = v.base ^ 32'h0005_0000;
          end
          @(negedge clk); cyc++;
          chk(disturb ? "R9 address under disturbance" : "R7 address held", mem_addr, exp_a);
          chk("R7 request held", 32'(mem_req), 32'd1);
        end
        start = 1'b0; laddr = v.va; table_base = v.base;
        mem_rvalid = 1'b1;
        mem_rdata = (reads == 0) ? v.e1 : v.e2;
        @(negedge clk); cyc++;
        mem_rvalid = 1'b0; mem_rdata = '0;
        reads++;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    chk("R8 done reached", 32'(done), 32'd1);
    chk((m_code(v) == 2'd1) ? "R5 read count" : "R6 read count", 32'(reads),
        (m_code(v) == 2'd1) ? 32'd1 : 32'd2);
    chk((m_code(v) == 2'd0) ? "R4 fault code" : (m_code(v) == 2'd1) ? "R5 fault code" : "R6 fault code",
        32'(fault_code), 32'(m_code(v)));
    chk((m_code(v) == 2'd0) ? "R4 physical address" : "R5_R6 zero address", phys_addr, m_pa(v));
    @(negedge clk);
    chk("R8 single done", 32'(done), 32'd0);
    chk("R8 idle after done", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 address held", phys_addr, m_pa(v));
    chk("R11 code held", 32'(fault_code), 32'(m_code(v)));
    chk("R9 no extra walk", 32'(busy), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 req in reset", 32'(mem_req), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 pa in reset", phys_addr, 32'd0);
    chk("R1 code in reset", 32'(fault_code), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_walk(VECS[i], 1'b0);

    // R10: stray response while idle
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h1111_1001;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    chk("R10 stray rvalid busy", 32'(busy), 32'd0);
    chk("R10 stray rvalid done", 32'(done), 32'd0);
    @(negedge clk);
    chk("R10 pa unchanged", phys_addr, m_pa(VECS[NV-1]));

    // R9: restart attempts and input changes while the first read is pending
    run_walk('{32'h0C03_5A5A, 32'h0020_0000, 32'h0066_6001, 32'h0099_9001, 8'd4}, 1'b1);
    run_walk('{32'hFFC0_0000, 32'h0030_0000, 32'h0000_0000, 32'h0000_0001, 8'd3}, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule